// File: doc/BRIEF.md
# Stereo Auto-Mute Detector

The detector watches a valid-strobed stream of signed audio sample pairs, one word per channel, and decides on its own when each channel has gone silent. A sample counts as silent ("static") when every bit is zero or every bit is one (the value -1). Once a channel has delivered a long unbroken run of such samples, the detector raises a mute request for that channel. The downstream volume stage performs its soft ramp and zero-cross gating, then answers with a one-cycle completion pulse. The detector then raises the channel's mute-control output, which stays high for the rest of the muted period. A single non-static sample on a channel drops both outputs for that channel at once. The two channels never influence each other.

The function is governed by an enable bit held in a one-bit configuration register. The register comes out of reset set, and a write strobe loads it. When the bit is cleared, the next sample strobe wipes every run count and releases every mute. No run is counted while the bit stays clear.

Top module: `amute_detector`

## Requirements
- R1: After reset both outputs are low, and auto-mute is already enabled: a full run of static samples mutes a channel with no configuration write.
- R2: The mute request of a channel rises on the second clock edge after the edge that accepts the THRESHOLD-th consecutive static sample of that channel (THRESHOLD defaults to 8192). After THRESHOLD-1 static samples it stays low.
- R3: A sample is static when all of its bits are 0 or all of its bits are 1. A run that mixes the two values counts as one unbroken run.
- R4: A single accepted non-static sample drops that channel's mute request and mute-control on the second edge after the accepting edge, and restarts its run from zero.
- R5: Each channel keeps its own run count and mute state. A non-static sample on one channel leaves the other channel's outputs unchanged.
- R6: While a channel's request is high and the ramp has not completed, a pulse on that channel's bit of `rampDone` raises `muteCtl` for the channel on the next edge. `muteCtl` is never high without `muteReq`. A pulse while the channel is not requesting is ignored.
- R7: The run count saturates at THRESHOLD. Any number of further static samples keeps the channel muted.
- R8: Writing 0 to the enable register (`cfgWr` with `cfgAutoMute`=0) releases all mutes on the next sample strobe, and no channel mutes while the bit is clear. After a write of 1, a fresh full run is needed.
- R9: Samples are accepted only in cycles with `sampleValid` high. Bus values in other cycles neither count nor release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Marks a cycle carrying one sample per channel |
| sampleBus | input | CHANNELS*SAMPLE_W | Channel 0 sample in the low bits, channel 1 above it |
| cfgWr | input | 1 | Write strobe for the enable register |
| cfgAutoMute | input | 1 | Value loaded into the enable register |
| rampDone | input | CHANNELS | Per-channel one-cycle completion pulse from the volume stage |
| muteReq | output | CHANNELS | Per-channel mute request to the volume stage |
| muteCtl | output | CHANNELS | Per-channel mute-control output, high while muted |

## Verification
The bench builds the detector with two channels of 24-bit samples and lowers THRESHOLD to 16. With that value the exact edge of the threshold, saturation after three times the run length and re-arming after a disable can each be reached in a few dozen samples. The same counter and compare logic serves the default 8192. Mixed 0/-1 runs, one-sided releases, stray ramp pulses and garbage on the bus during invalid cycles are each driven against a reference model kept in the bench.

// File: rtl/amute_pkg.sv
package amute_pkg;

  // Strobes from control to the run-length datapath, shared by all channels.
  typedef struct packed {
    logic countEn;  // accepted sample, detection enabled
    logic flush;    // accepted sample, detection disabled: wipe runs
  } runCtrl_t;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RAMP  = 2'd1,
    CH_MUTED = 2'd2
  } chState_t;

endpackage

// File: rtl/amute_datapath.sv
module amute_datapath
  import amute_pkg::*;
#(
  parameter int CHANNELS  = 2,
  parameter int SAMPLE_W  = 24,
  parameter int THRESHOLD = 8192
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  runCtrl_t                     ctrl,
  input  logic [CHANNELS*SAMPLE_W-1:0] sampleBus,
  output logic [CHANNELS-1:0]          runFull
);

  localparam int CNT_W = $clog2(THRESHOLD + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESHOLD);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [SAMPLE_W-1:0] word;
    logic                isStatic;
    logic [CNT_W-1:0]    runCnt;

    assign word     = sampleBus[ch*SAMPLE_W +: SAMPLE_W];
    // silent when every bit is 0 or every bit is 1
    assign isStatic = (&word) | ~(|word);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        runCnt <= '0;
      end else if (ctrl.flush) begin
        runCnt <= '0;
      end else if (ctrl.countEn) begin
        if (!isStatic) begin
          runCnt <= '0;
        end else if (runCnt != LIMIT) begin
          runCnt <= runCnt + ONE;
        end
      end
    end

    assign runFull[ch] = (runCnt == LIMIT);
  end

endmodule

// File: rtl/amute_control.sv
module amute_control
  import amute_pkg::*;
#(
  parameter int CHANNELS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic                cfgWr,
  input  logic                cfgAutoMute,
  input  logic [CHANNELS-1:0] runFull,
  input  logic [CHANNELS-1:0] rampDone,
  output runCtrl_t            ctrl,
  output logic                autoEn,
  output logic [CHANNELS-1:0] muteReq,
  output logic [CHANNELS-1:0] muteCtl
);

  // enable bit: comes out of reset set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      autoEn <= 1'b1;
    end else if (cfgWr) begin
      autoEn <= cfgAutoMute;
    end
  end

  always_comb begin
    ctrl.countEn = sampleValid & autoEn;
    ctrl.flush   = sampleValid & ~autoEn;
  end

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_fsm
    chState_t state, stateNxt;

    always_comb begin
      stateNxt = state;
      unique case (state)
        CH_IDLE:  if (runFull[ch]) stateNxt = CH_RAMP;
        CH_RAMP: begin
          if (!runFull[ch])      stateNxt = CH_IDLE;
          else if (rampDone[ch]) stateNxt = CH_MUTED;
        end
        CH_MUTED: if (!runFull[ch]) stateNxt = CH_IDLE;
        default:  stateNxt = CH_IDLE;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) state <= CH_IDLE;
      else       state <= stateNxt;
    end

    assign muteReq[ch] = (state != CH_IDLE);
    assign muteCtl[ch] = (state == CH_MUTED);
  end

endmodule

// File: rtl/amute_detector.sv
module amute_detector
  import amute_pkg::*;
#(
  parameter int CHANNELS  = 2,
  parameter int SAMPLE_W  = 24,
  parameter int THRESHOLD = 8192
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sampleValid,
  input  logic [CHANNELS*SAMPLE_W-1:0] sampleBus,
  input  logic                         cfgWr,
  input  logic                         cfgAutoMute,
  input  logic [CHANNELS-1:0]          rampDone,
  output logic [CHANNELS-1:0]          muteReq,
  output logic [CHANNELS-1:0]          muteCtl
);

  runCtrl_t            ctrl;
  logic [CHANNELS-1:0] runFull;
  logic                autoEn;

  amute_datapath #(
    .CHANNELS (CHANNELS),
    .SAMPLE_W (SAMPLE_W),
    .THRESHOLD(THRESHOLD)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .sampleBus(sampleBus),
    .runFull  (runFull)
  );

  amute_control #(
    .CHANNELS(CHANNELS)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .cfgWr      (cfgWr),
    .cfgAutoMute(cfgAutoMute),
    .runFull    (runFull),
    .rampDone   (rampDone),
    .ctrl       (ctrl),
    .autoEn     (autoEn),
    .muteReq    (muteReq),
    .muteCtl    (muteCtl)
  );

endmodule

// File: rtl/amute_checker.sv
module amute_checker #(
  parameter int CHANNELS = 2,
  parameter int SAMPLE_W = 24
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         sampleValid,
  input logic [CHANNELS*SAMPLE_W-1:0] sampleBus,
  input logic                         autoEn,
  input logic [CHANNELS-1:0]          muteReq,
  input logic [CHANNELS-1:0]          muteCtl
);

  // request can only move two edges after an accepted sample
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> ##1 $stable(muteReq));

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chk
    logic [SAMPLE_W-1:0] w;
    logic                silent;
    assign w      = sampleBus[ch*SAMPLE_W +: SAMPLE_W];
    assign silent = (w == '0) || (w == '1);

    assert_ctl_needs_req_R6: assert property (@(posedge clk) disable iff (!rstN)
      muteCtl[ch] |-> muteReq[ch]);

    assert_release_R4: assert property (@(posedge clk) disable iff (!rstN)
      (sampleValid && autoEn && !silent) |=> ##1 !muteReq[ch]);

    assert_rise_on_static_R3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(muteReq[ch]) |-> ($past(sampleValid, 2) && $past(silent, 2)));

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
      (sampleValid && !autoEn) |=> ##1 !muteReq[ch]);
  end

endmodule

bind amute_detector amute_checker #(
  .CHANNELS(CHANNELS),
  .SAMPLE_W(SAMPLE_W)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .sampleBus  (sampleBus),
  .autoEn     (autoEn),
  .muteReq    (muteReq),
  .muteCtl    (muteCtl)
);

// File: tb/amute_detector_bench.sv
`timescale 1ns/1ps
module amute_detector_bench;

  localparam int CH = 2;
  localparam int W  = 24;
  localparam int T  = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            sampleValid = 1'b0;
  logic [CH*W-1:0] sampleBus = '0;
  logic            cfgWr = 1'b0;
  logic            cfgAutoMute = 1'b0;
  logic [CH-1:0]   rampDone = '0;
  logic [CH-1:0]   muteReq;
  logic [CH-1:0]   muteCtl;

  always #2.5 clk = ~clk;

  amute_detector #(.CHANNELS(CH), .SAMPLE_W(W), .THRESHOLD(T)) u_amute_detector (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleBus(sampleBus),
    .cfgWr(cfgWr), .cfgAutoMute(cfgAutoMute), .rampDone(rampDone),
    .muteReq(muteReq), .muteCtl(muteCtl));

  typedef struct {
    logic [CH-1:0] req;
    logic [CH-1:0] ctl;
    string         tag;
  } item_t;

  item_t scq[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 0;

  // reference model: 0 idle, 1 ramping, 2 muted
  int  mCnt [CH];
  int  mSt  [CH];
  bit  mEn = 1;

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] NEG1 = '1;

  task automatic push(string tag);
    item_t it;
    for (int c = 0; c < CH; c++) begin
      it.req[c] = (mSt[c] != 0);
      it.ctl[c] = (mSt[c] == 2);
    end
    it.tag = tag;
    scq.push_back(it);
  endtask

  task automatic sendPair(logic [W-1:0] l, logic [W-1:0] r, string tag);
    logic [W-1:0] v;
    sampleValid = 1'b1;
    sampleBus   = {r, l};
    for (int c = 0; c < CH; c++) begin
      v = (c == 0) ? l : r;
      if (!mEn) mCnt[c] = 0;
      else if (v == ZERO || v == NEG1) mCnt[c] = (mCnt[c] < T) ? mCnt[c] + 1 : T;
      else mCnt[c] = 0;
      if (mCnt[c] != T) mSt[c] = 0;
      else if (mSt[c] == 0) mSt[c] = 1;
    end
    @(negedge clk);
    sampleValid = 1'b0;
    @(negedge clk);
    push(tag);
    @(negedge clk);
  endtask

  task automatic pulseAck(logic [CH-1:0] m, string tag);
    rampDone = m;
    for (int c = 0; c < CH; c++)
      if (m[c] && mSt[c] == 1) mSt[c] = 2;
    @(negedge clk);
    rampDone = '0;
    push(tag);
    @(negedge clk);
  endtask

  task automatic writeEn(bit e, string tag);
    cfgWr = 1'b1; cfgAutoMute = e;
    @(negedge clk);
    cfgWr = 1'b0;
    mEn = e;
    push(tag);
    @(negedge clk);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      while (scq.size() > 0) begin
        it = scq.pop_front();
        nChecks++;
        if (muteReq !== it.req || muteCtl !== it.ctl) begin
          nFails++;
          $display("FAIL %s: req=%b ctl=%b expected req=%b ctl=%b",
                   it.tag, muteReq, muteCtl, it.req, it.ctl);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < CH; c++) begin mCnt[c] = 0; mSt[c] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    push("R1 reset state");
    @(negedge clk);

    // R1/R2: default-enabled, threshold edge
    for (int i = 0; i < T - 1; i++) sendPair(ZERO, NEG1, "R2 below threshold");
    sendPair(ZERO, NEG1, "R1 R2 mute at threshold");

    // R6: ramp completion per channel
    pulseAck(2'b01, "R6 ack ch0");
    pulseAck(2'b10, "R6 ack ch1");

    // R7: saturation
    for (int i = 0; i < 3 * T; i++) sendPair(NEG1, ZERO, "R7 saturated run");

    // R4/R5: release only the left channel
    sendPair(24'h000123, ZERO, "R4 R5 left release");

    // R3: mixed 0/-1 run on left
    for (int i = 0; i < T; i++)
      sendPair((i % 2 == 0) ? ZERO : NEG1, NEG1, "R3 mixed run");

    // R6: stray ack while idle ignored
    sendPair(24'h800000, 24'h7FFFFF, "R4 both release");
    pulseAck(2'b11, "R6 ack ignored when idle");
    for (int i = 0; i < T; i++) sendPair(ZERO, ZERO, "R6 fresh run no ctl");

    // R9: garbage on bus without valid
    sampleBus = {24'h123456, 24'h654321};
    repeat (6) @(negedge clk);
    push("R9 invalid cycles ignored");
    @(negedge clk);
    sendPair(ZERO, ZERO, "R9 still muted");

    // R8: disable, then re-enable
    writeEn(1'b0, "R8 write 0 waits for strobe");
    sendPair(ZERO, ZERO, "R8 released on strobe");
    for (int i = 0; i < 2 * T; i++) sendPair(ZERO, ZERO, "R8 no mute while disabled");
    writeEn(1'b1, "R8 re-enable");
    for (int i = 0; i < T; i++) sendPair(NEG1, NEG1, "R8 fresh run after enable");
    sendPair(ZERO, 24'h000001, "R5 right release only");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule